// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Legality Checker

This block watches the command pins of a DDR SDRAM. It sits beside a device model or inside a controller monitor. On every rising clock edge it combines the clock-enable level from the previous edge with the current one and with the select, row-strobe, column-strobe and write-enable pins. From these it resolves one command and registers a 4-bit command code. At the same edge it raises a violation flag with a 3-bit reason whenever the command breaks the rules below.

The block keeps its own view of the device. It tracks which of the banks hold an open row, and it counts down a per-bank lockout after every read or write with auto-precharge. It counts the cycles since the last precharge. It also follows the power mode: normal, power-down with all banks closed, power-down with a row open, or self refresh. A flagged command never changes the bank state or enters a low-power mode. Burst length, precharge time and write-recovery time are parameters, and the lockout windows are derived from them.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock enable high on both edges, the pins {cs_n,ras_n,cas_n,we_n} decode as follows:
  - cs_n high gives code 0 (deselect).
  - 0111 gives code 1 (no-op).
  - 0011 gives code 2 (activate).
  - 0101 gives code 3 (read), or code 4 when addr[10] is high.
  - 0100 gives code 5 (write), or code 6 when addr[10] is high.
  - 0010 gives code 7 (precharge one bank), or code 8 (precharge all) when addr[10] is high.
  - 0110 gives code 9 (burst stop).
  - 0001 gives code 10 (auto refresh).
  - 0000 gives code 11 (mode register write).
- R2: An activate opens the bank selected by ba, shown as bit ba of bank_open. An activate to a bank that is already open is flagged with reason 1. A flagged command never changes bank_open.
- R3: A read or write to a closed bank is flagged with reason 2. A legal read or write with auto-precharge (addr[10] high) closes its bank at once.
- R4: A precharge with addr[10] low closes only bank ba. With addr[10] high it closes every bank and ba is ignored.
- R5: After a read with auto-precharge at cycle n, any activate, read, write or precharge to that bank in cycles n+1 to n+BURST_LEN/2+T_RP-1 is flagged with reason 3. A precharge-all is flagged while any bank is locked.
- R6: After a write with auto-precharge at cycle n, the same lockout with reason 3 lasts through cycle n+BURST_LEN/2+1+T_WR+T_RP-1.
- R7: A mode register write is flagged with reason 4 while any bank is open or locked. It is flagged with reason 5 when fewer than T_RP cycles have passed since the last legal precharge. A legal one registers {ba,addr} on mode_word.
- R8: An auto refresh, and a self-refresh entry, are flagged with reason 4 while any bank is open or locked.
- R9: When clock enable falls, the refresh pins give code 12 and self refresh (pwr_state 3). Deselect or no-op pins give code 13 and power-down: pwr_state 1 if no bank is open, 2 otherwise. Any other pins keep their R1 code, are flagged with reason 7, and leave pwr_state at 0.
- R10: When clock enable rises, the code is 14 and pwr_state returns to 0. This exit is flagged with reason 6 unless the pins show deselect or no-op.
- R11: With clock enable low on both edges, the code is 15. While pwr_state is not 0, cs_n low with pins other than no-op is flagged with reason 6 and changes nothing.
- R12: After reset the outputs are: code 1, no violation, reason 0, pwr_state 0, all banks closed, and mode_word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_BITS | Bank address |
| addr | input | ADDR_W | Address bus; bit 10 selects auto/all precharge |
| cmd_code | output | 4 | Registered decoded command code |
| viol | output | 1 | Registered violation flag |
| viol_why | output | 3 | Registered violation reason |
| pwr_state | output | 2 | Power mode: 0 normal, 1/2 power-down, 3 self refresh |
| bank_open | output | 2**BANK_BITS | One bit per bank, high when open |
| mode_word | output | BANK_BITS+ADDR_W | Last legal mode register opcode |

## Verification
The bench probes the last cycle of each lockout and the first cycle after it. A window that is off by one would either flag a legal activate or let an early one through. It also issues a mode register write exactly T_RP-1 and T_RP cycles after a precharge, and checks that a precharge-all with an unrelated ba empties every bank. Clock-enable edges with wrong pins are driven as well: a refresh with a row open, a read on a falling enable, and an activate on the rising one. A design that read the enable level alone, rather than both edges, would enter the wrong mode or miss these flags.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [3:0] {
    C_DESEL = 4'd0,
    C_NOP   = 4'd1,
    C_ACT   = 4'd2,
    C_RD    = 4'd3,
    C_RDA   = 4'd4,
    C_WR    = 4'd5,
    C_WRA   = 4'd6,
    C_PRE   = 4'd7,
    C_PREA  = 4'd8,
    C_BST   = 4'd9,
    C_REF   = 4'd10,
    C_MRS   = 4'd11,
    C_SRE   = 4'd12,
    C_PDE   = 4'd13,
    C_EXIT  = 4'd14,
    C_HOLD  = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    W_NONE   = 3'd0,
    W_OPEN   = 3'd1,
    W_CLOSED = 3'd2,
    W_LOCKED = 3'd3,
    W_BUSY   = 3'd4,
    W_TRP    = 3'd5,
    W_ASLEEP = 3'd6,
    W_CKE    = 3'd7
  } why_e;

  typedef enum logic [1:0] {
    P_NORM  = 2'd0,
    P_PDPRE = 2'd1,
    P_PDACT = 2'd2,
    P_SELF  = 2'd3
  } pwr_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e pin_cmd,
  output cmd_e cmd,
  output logic quiet
);

  // Command implied by the strobe pins alone
  always_comb begin
    pin_cmd = C_DESEL;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  pin_cmd = C_NOP;
        3'b011:  pin_cmd = C_ACT;
        3'b101:  pin_cmd = a10 ? C_RDA : C_RD;
        3'b100:  pin_cmd = a10 ? C_WRA : C_WR;
        3'b010:  pin_cmd = a10 ? C_PREA : C_PRE;
        3'b110:  pin_cmd = C_BST;
        3'b001:  pin_cmd = C_REF;
        default: pin_cmd = C_MRS;
      endcase
    end
  end

  assign quiet = (pin_cmd == C_DESEL) || (pin_cmd == C_NOP);

  // Clock-enable transition selects the command class
  always_comb begin
    unique case ({cke_prev, cke})
      2'b11: cmd = pin_cmd;
      2'b10: begin
        if (pin_cmd == C_REF)  cmd = C_SRE;
        else if (quiet)        cmd = C_PDE;
        else                   cmd = pin_cmd;
      end
      2'b01:   cmd = C_EXIT;
      default: cmd = C_HOLD;
    endcase
  end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int NBANK  = 4,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [NBANK-1:0]  open_set,
  input  logic [NBANK-1:0]  close_clr,
  input  logic [NBANK-1:0]  lock_ld,
  input  logic [LOCK_W-1:0] lock_val,
  output logic [NBANK-1:0]  open_q,
  output logic [NBANK-1:0]  locked
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              open_d;
    logic [LOCK_W-1:0] cnt_q, cnt_d;
    logic              open_en, cnt_en;

    always_comb begin
      open_en = open_set[b] | close_clr[b];
      open_d  = open_set[b];
      cnt_en  = lock_ld[b] | (cnt_q != '0);
      cnt_d   = lock_ld[b] ? lock_val : cnt_q - LOCK_W'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        open_q[b] <= 1'b0;
        cnt_q     <= '0;
      end else begin
        if (open_en) open_q[b] <= open_d;
        if (cnt_en)  cnt_q     <= cnt_d;
      end
    end

    assign locked[b] = (cnt_q != '0);
  end

endmodule

// File: rtl/ddr_pwr_tracker.sv
module ddr_pwr_tracker
  import ddr_mon_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  cmd_e cmd,
  input  logic legal,
  input  logic any_open,
  output pwr_e state
);

  pwr_e state_d;
  logic state_en;

  always_comb begin
    state_d = state;
    if (cmd == C_EXIT)
      state_d = P_NORM;
    else if (legal && cmd == C_SRE)
      state_d = P_SELF;
    else if (legal && cmd == C_PDE)
      state_d = any_open ? P_PDACT : P_PDPRE;
    state_en = (state_d != state);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       state <= P_NORM;
    else if (state_en) state <= state_d;
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ADDR_W    = 12,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cke,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic [BANK_BITS-1:0]        ba,
  input  logic [ADDR_W-1:0]           addr,
  output logic [3:0]                  cmd_code,
  output logic                        viol,
  output logic [2:0]                  viol_why,
  output logic [1:0]                  pwr_state,
  output logic [(1<<BANK_BITS)-1:0]   bank_open,
  output logic [BANK_BITS+ADDR_W-1:0] mode_word
);

  localparam int NBANK   = 1 << BANK_BITS;
  localparam int RDA_WIN = BURST_LEN / 2 + T_RP;
  localparam int WRA_WIN = BURST_LEN / 2 + 1 + T_WR + T_RP;
  localparam int LOCK_W  = $clog2(WRA_WIN + 1);
  localparam int TRP_W   = $clog2(T_RP + 1);
  localparam int MW      = BANK_BITS + ADDR_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  // Previous clock-enable level
  logic cke_prev;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cke_prev <= 1'b1;
    else         cke_prev <= cke;
  end

  cmd_e pin_cmd, cmd;
  logic quiet;

  ddr_cmd_decode u_dec (
    .cke_prev (cke_prev),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (addr[10]),
    .pin_cmd  (pin_cmd),
    .cmd      (cmd),
    .quiet    (quiet)
  );

  logic [NBANK-1:0]  open_q, locked;
  logic [NBANK-1:0]  open_set, close_clr, lock_ld, ba_hot;
  logic [LOCK_W-1:0] lock_val;
  pwr_e              pwr;
  logic [TRP_W-1:0]  trp_q, trp_d;
  logic              trp_en;

  why_e why_d;
  logic ok;
  logic hit_open, hit_lock, any_open, any_lock, busy, entry_bad;

  always_comb begin
    ba_hot    = NBANK'(1) << ba;
    hit_open  = open_q[ba];
    hit_lock  = locked[ba];
    any_open  = |open_q;
    any_lock  = |locked;
    busy      = any_open | any_lock;
    entry_bad = cke_prev && !cke && (cmd != C_SRE) && (cmd != C_PDE);
  end

  // Legality of the resolved command
  always_comb begin
    why_d = W_NONE;
    if (entry_bad) begin
      why_d = W_CKE;
    end else begin
      unique case (cmd)
        C_ACT: begin
          if (hit_lock)      why_d = W_LOCKED;
          else if (hit_open) why_d = W_OPEN;
        end
        C_RD, C_RDA, C_WR, C_WRA: begin
          if (hit_lock)       why_d = W_LOCKED;
          else if (!hit_open) why_d = W_CLOSED;
        end
        C_PRE:  if (hit_lock) why_d = W_LOCKED;
        C_PREA: if (any_lock) why_d = W_LOCKED;
        C_MRS: begin
          if (busy)              why_d = W_BUSY;
          else if (trp_q != '0)  why_d = W_TRP;
        end
        C_REF, C_SRE: if (busy) why_d = W_BUSY;
        C_EXIT: if (!quiet) why_d = W_ASLEEP;
        C_HOLD: if (pwr != P_NORM && !cs_n && pin_cmd != C_NOP) why_d = W_ASLEEP;
        default: why_d = W_NONE;
      endcase
    end
    ok = (why_d == W_NONE);
  end

  // Bank state updates for legal commands
  always_comb begin
    open_set  = '0;
    close_clr = '0;
    lock_ld   = '0;
    lock_val  = LOCK_W'(RDA_WIN - 1);
    if (ok) begin
      unique case (cmd)
        C_ACT: open_set = ba_hot;
        C_RDA: begin
          close_clr = ba_hot;
          lock_ld   = ba_hot;
        end
        C_WRA: begin
          close_clr = ba_hot;
          lock_ld   = ba_hot;
          lock_val  = LOCK_W'(WRA_WIN - 1);
        end
        C_PRE:   close_clr = ba_hot;
        C_PREA:  close_clr = '1;
        default: ;
      endcase
    end
  end

  ddr_bank_tracker #(
    .NBANK  (NBANK),
    .LOCK_W (LOCK_W)
  ) u_banks (
    .clk       (clk),
    .arst_n    (arst_n),
    .open_set  (open_set),
    .close_clr (close_clr),
    .lock_ld   (lock_ld),
    .lock_val  (lock_val),
    .open_q    (open_q),
    .locked    (locked)
  );

  ddr_pwr_tracker u_pwr (
    .clk      (clk),
    .arst_n   (arst_n),
    .cmd      (cmd),
    .legal    (ok),
    .any_open (any_open),
    .state    (pwr)
  );

  // Cycles since the last legal precharge
  always_comb begin
    trp_en = 1'b0;
    trp_d  = trp_q;
    if (ok && (cmd == C_PRE || cmd == C_PREA)) begin
      trp_en = 1'b1;
      trp_d  = TRP_W'(T_RP - 1);
    end else if (trp_q != '0) begin
      trp_en = 1'b1;
      trp_d  = trp_q - TRP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     trp_q <= '0;
    else if (trp_en) trp_q <= trp_d;
  end

  // Output registers
  logic          mode_en;
  logic [MW-1:0] mode_d;

  always_comb begin
    mode_en = ok && (cmd == C_MRS);
    mode_d  = {ba, addr};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cmd_code  <= C_NOP;
      viol      <= 1'b0;
      viol_why  <= W_NONE;
      mode_word <= '0;
    end else begin
      cmd_code <= cmd;
      viol     <= !ok;
      viol_why <= why_d;
      if (mode_en) mode_word <= mode_d;
    end
  end

  assign pwr_state = pwr;
  assign bank_open = open_q;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk #(
  parameter int BANK_BITS = 2
) (
  input logic                        clk,
  input logic                        arst_n,
  input logic [BANK_BITS-1:0]        ba,
  input logic [3:0]                  cmd_code,
  input logic                        viol,
  input logic [1:0]                  pwr_state,
  input logic [(1<<BANK_BITS)-1:0]   bank_open
);

  // R2: a legal activate leaves its bank open
  a_r2_act_opens: assert property (@(posedge clk) disable iff (!arst_n)
    (cmd_code == 4'd2 && !viol) |-> bank_open[$past(ba)]);

  // R9: precharge power-down only with every bank closed
  a_r9_pdpre_idle: assert property (@(posedge clk) disable iff (!arst_n)
    (pwr_state == 2'd1) |-> (bank_open == '0));

  // R9: active power-down only with a row open
  a_r9_pdact_busy: assert property (@(posedge clk) disable iff (!arst_n)
    (pwr_state == 2'd2) |-> (bank_open != '0));

  // R9: self refresh is entered only from normal mode
  a_r9_self_from_norm: assert property (@(posedge clk) disable iff (!arst_n)
    (pwr_state == 2'd3 && $past(pwr_state) != 2'd3) |-> ($past(pwr_state) == 2'd0));

  // R10: an exit always lands in normal mode
  a_r10_exit_norm: assert property (@(posedge clk) disable iff (!arst_n)
    (cmd_code == 4'd14) |-> (pwr_state == 2'd0));

  // R11: bank state frozen while asleep
  a_r11_asleep_frozen: assert property (@(posedge clk) disable iff (!arst_n)
    (pwr_state != 2'd0 && $past(pwr_state) != 2'd0) |-> $stable(bank_open));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(
  .BANK_BITS (BANK_BITS)
) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .ba        (ba),
  .cmd_code  (cmd_code),
  .viol      (viol),
  .pwr_state (pwr_state),
  .bank_open (bank_open)
);

// File: tb/ddr_cmd_monitor_test.sv
module ddr_cmd_monitor_test;

  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                         P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                         P_BST = 4'b0110, P_REF = 4'b0001, P_MRS = 4'b0000;
  localparam logic [11:0] AP = 12'h400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  cmd_code;
  logic        viol;
  logic [2:0]  viol_why;
  logic [1:0]  pwr_state;
  logic [3:0]  bank_open;
  logic [13:0] mode_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ddr_cmd_monitor uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .viol(viol), .viol_why(viol_why), .pwr_state(pwr_state),
    .bank_open(bank_open), .mode_word(mode_word)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // One command cycle; outputs sampled just after the capturing edge
  task automatic step(input logic k, input logic [3:0] p,
                      input logic [1:0] b, input logic [11:0] a);
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b;
    addr = a;
    @(posedge clk);
    #2;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(1'b1, P_NOP, 2'd0, 12'h0);
  endtask

  task automatic expect_cmd(input string tag, input int code, input int why);
    chk({tag, " code"}, cmd_code, code);
    chk({tag, " viol"}, viol, (why != 0) ? 1 : 0);
    chk({tag, " why"}, viol_why, why);
  endtask

  task automatic t_reset;
    nops(3);
    chk("R12 code", cmd_code, 1);
    chk("R12 viol", viol, 0);
    chk("R12 pwr", pwr_state, 0);
    chk("R12 banks", bank_open, 0);
    chk("R12 mode_word", mode_word, 0);
  endtask

  task automatic t_decode;
    step(1'b1, P_DES, 2'd0, 12'h0); expect_cmd("R1 deselect", 0, 0);
    step(1'b1, P_NOP, 2'd0, 12'h0); expect_cmd("R1 nop", 1, 0);
    step(1'b1, P_BST, 2'd0, 12'h0); expect_cmd("R1 burst stop", 9, 0);
    step(1'b1, P_ACT, 2'd0, 12'h0); expect_cmd("R1 activate", 2, 0);
    step(1'b1, P_RD,  2'd0, 12'h0); expect_cmd("R1 read", 3, 0);
    step(1'b1, P_WR,  2'd0, 12'h0); expect_cmd("R1 write", 5, 0);
    step(1'b1, P_PRE, 2'd0, 12'h0); expect_cmd("R1 precharge", 7, 0);
    step(1'b1, P_REF, 2'd0, 12'h0); expect_cmd("R1 refresh", 10, 0);
    nops(1);
    step(1'b1, P_MRS, 2'd2, 12'h123); expect_cmd("R1 mode write", 11, 0);
    chk("R7 mode_word", mode_word, 14'h2123);
  endtask

  task automatic t_bank;
    step(1'b1, P_ACT, 2'd1, 12'h0); expect_cmd("R2 act b1", 2, 0);
    step(1'b1, P_ACT, 2'd1, 12'h0); expect_cmd("R2 act open", 2, 1);
    chk("R2 banks unchanged", bank_open, 4'b0010);
    step(1'b1, P_RD, 2'd2, 12'h0); expect_cmd("R3 read closed", 3, 2);
    step(1'b1, P_WR, 2'd3, 12'h0); expect_cmd("R3 write closed", 5, 2);
    step(1'b1, P_ACT, 2'd2, 12'h0);
    step(1'b1, P_ACT, 2'd3, 12'h0);
    chk("R2 three open", bank_open, 4'b1110);
    step(1'b1, P_PRE, 2'd2, 12'h0); expect_cmd("R4 pre one", 7, 0);
    chk("R4 one closed", bank_open, 4'b1010);
    step(1'b1, P_PRE, 2'd2, AP); expect_cmd("R4 pre all", 8, 0);
    chk("R4 all closed", bank_open, 4'b0000);
  endtask

  task automatic t_rda;
    nops(3);
    step(1'b1, P_ACT, 2'd0, 12'h0);
    step(1'b1, P_RD, 2'd0, AP); expect_cmd("R3 read ap", 4, 0);
    chk("R3 ap closes", bank_open, 0);
    nops(3);
    step(1'b1, P_ACT, 2'd0, 12'h0); expect_cmd("R5 last locked", 2, 3);
    step(1'b1, P_ACT, 2'd0, 12'h0); expect_cmd("R5 window over", 2, 0);
    chk("R5 reopened", bank_open, 4'b0001);
    step(1'b1, P_PRE, 2'd0, 12'h0);
  endtask

  task automatic t_wra;
    nops(3);
    step(1'b1, P_ACT, 2'd3, 12'h0);
    step(1'b1, P_WR, 2'd3, AP); expect_cmd("R6 write ap", 6, 0);
    nops(1);
    step(1'b1, P_PRE, 2'd1, AP); expect_cmd("R5 pre all locked", 8, 3);
    nops(4);
    step(1'b1, P_RD, 2'd3, 12'h0); expect_cmd("R6 read locked", 3, 3);
    step(1'b1, P_ACT, 2'd3, 12'h0); expect_cmd("R6 window over", 2, 0);
    step(1'b1, P_PRE, 2'd3, 12'h0);
  endtask

  task automatic t_mrs;
    nops(3);
    step(1'b1, P_ACT, 2'd0, 12'h0);
    step(1'b1, P_MRS, 2'd1, 12'h055); expect_cmd("R7 busy", 11, 4);
    step(1'b1, P_PRE, 2'd0, 12'h0);
    step(1'b1, P_MRS, 2'd1, 12'h055); expect_cmd("R7 trp 1", 11, 5);
    step(1'b1, P_MRS, 2'd1, 12'h055); expect_cmd("R7 trp 2", 11, 5);
    chk("R7 word kept", mode_word, 14'h2123);
    step(1'b1, P_MRS, 2'd1, 12'h055); expect_cmd("R7 trp met", 11, 0);
    chk("R7 word new", mode_word, 14'h1055);
  endtask

  task automatic t_ref;
    step(1'b1, P_ACT, 2'd1, 12'h0);
    step(1'b1, P_REF, 2'd0, 12'h0); expect_cmd("R8 refresh busy", 10, 4);
    step(1'b0, P_REF, 2'd0, 12'h0); expect_cmd("R8 self entry busy", 12, 4);
    chk("R8 stays normal", pwr_state, 0);
    step(1'b1, P_NOP, 2'd0, 12'h0); expect_cmd("R10 exit", 14, 0);
    step(1'b1, P_PRE, 2'd1, 12'h0);
  endtask

  task automatic t_pwr;
    nops(3);
    step(1'b0, P_NOP, 2'd0, 12'h0); expect_cmd("R9 pd entry", 13, 0);
    chk("R9 pd precharge", pwr_state, 1);
    step(1'b0, P_DES, 2'd0, 12'h0); expect_cmd("R11 hold", 15, 0);
    step(1'b0, P_ACT, 2'd2, 12'h0); expect_cmd("R11 cmd asleep", 15, 6);
    chk("R11 act ignored", bank_open, 0);
    step(1'b1, P_DES, 2'd0, 12'h0); expect_cmd("R10 pd exit", 14, 0);
    chk("R10 normal", pwr_state, 0);
    step(1'b1, P_ACT, 2'd2, 12'h0);
    step(1'b0, P_DES, 2'd0, 12'h0); expect_cmd("R9 pd active", 13, 0);
    chk("R9 pd active state", pwr_state, 2);
    step(1'b1, P_NOP, 2'd0, 12'h0);
    step(1'b1, P_PRE, 2'd2, 12'h0);
    nops(3);
    step(1'b0, P_REF, 2'd0, 12'h0); expect_cmd("R9 self entry", 12, 0);
    chk("R9 self state", pwr_state, 3);
    step(1'b0, P_NOP, 2'd0, 12'h0); expect_cmd("R11 self hold", 15, 0);
    step(1'b1, P_ACT, 2'd0, 12'h0); expect_cmd("R10 bad exit", 14, 6);
    chk("R10 bad exit normal", pwr_state, 0);
    chk("R10 bad exit banks", bank_open, 0);
    step(1'b0, P_RD, 2'd0, 12'h0); expect_cmd("R9 bad entry", 3, 7);
    chk("R9 bad entry state", pwr_state, 0);
    step(1'b1, P_NOP, 2'd0, 12'h0);
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0;
    cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_DES;
    ba = '0;
    addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_decode;
    t_bank;
    t_rda;
    t_wra;
    t_mrs;
    t_ref;
    t_pwr;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule